// File: doc/BRIEF.md
# Pixel Mask and Alpha Blend Unit

This unit sits in the pixel path in front of a display. It takes a stream of 16-bit RGB pixels (5 bits red, 6 bits green, 5 bits blue) and applies a configured operation to each one. A pixel that equals the programmed mask colour can be dropped. A pixel can also be mixed with a second colour using an 8-bit alpha factor. The unit can do both of these, or neither, in which case the pixel passes through unchanged.

The blend foreground is either the incoming stream pixel or the second programmable colour register. Whichever one is not the foreground acts as the background. The surrounding logic holds the configuration: a two-bit operation select, the mask colour, the alpha factor, two colour registers and a source select. Pixels enter and leave on a valid/ready handshake. There is one register stage, and the input ready signal is the downstream ready passed straight through.

Top module: `pix_blend_unit`

## Requirements
- R1: While `rstN` is low, and on the first clock edge after it rises, `outValid` is 0.
- R2: A pixel is accepted on a rising edge where `inValid` and `inReady` are both 1. Its result appears on `outData`, with `outValid` set to 1, right after that same edge. If an edge with `outReady` high accepts no pixel, `outValid` goes to 0.
- R3: `inReady` equals `outReady`. While `outReady` is 0, `outValid` and `outData` hold their values.
- R4: `cfgMode` encoding: 0 = off, 1 = mask only, 2 = blend only, 3 = mask then blend. Bit 0 enables masking and bit 1 enables blending.
- R5: In mode 0, each accepted pixel comes out bit-for-bit unchanged.
- R6: In modes 1 and 3, an accepted pixel equal to `cfgMask` is consumed without producing output. `outValid` is 0 after that edge and `outData` keeps its old value.
- R7: In mode 1, a pixel that differs from `cfgMask` passes through unchanged. In mode 2, a pixel equal to `cfgMask` is not dropped.
- R8: Blending works on each channel separately. The fields are red [15:11], green [10:5] and blue [4:0]. Each channel result is (alpha·fg + (256−alpha)·bg) >> 8, with alpha = `cfgAlpha`.
- R9: When `cfgSrcSel` is 1, fg = `cfgPixel1` and bg = the stream pixel. When `cfgSrcSel` is 0, fg = the stream pixel and bg = `cfgPixel0`.
- R10: In mode 3, the mask compare uses the raw stream pixel, not the blended result. A pixel whose blended value happens to equal `cfgMask` is still output.
- R11: An alpha of 0 yields the background colour exactly: `cfgPixel0` when `cfgSrcSel` is 0, and the stream pixel when `cfgSrcSel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Operation select (R4) |
| cfgMask | input | 16 | Mask colour |
| cfgAlpha | input | 8 | Blend factor |
| cfgPixel0 | input | 16 | Colour register 0 (background when the stream is foreground) |
| cfgPixel1 | input | 16 | Colour register 1 (foreground when selected) |
| cfgSrcSel | input | 1 | 1 = colour register 1 is the foreground, 0 = the stream is |
| inValid | input | 1 | Input pixel valid |
| inData | input | 16 | Input RGB565 pixel |
| inReady | output | 1 | Input pixel can be taken |
| outValid | output | 1 | Output pixel valid |
| outData | output | 16 | Output RGB565 pixel |
| outReady | input | 1 | Downstream can take a pixel |

## Verification
Every result is due exactly one edge after acceptance: the pass-through value, the blended value, and the missing `outValid` for a dropped pixel. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so each check reads the single register stage right after it loads. For stalls, `inReady` is sampled shortly after the falling edge at which `outReady` drops. The output is then compared on each of several stalled edges to confirm it holds. After `outReady` returns, the waiting pixel is checked one edge later.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  localparam int PIX_W   = 16;
  localparam int ALPHA_W = 8;
  localparam int MODE_W  = 2;
  localparam int NUM_CH  = 3;
  localparam int CH_MAXW = 6;
  localparam int ACC_W   = ALPHA_W + CH_MAXW + 1;
  localparam int CH_LSB [NUM_CH] = '{11, 5, 0};
  localparam int CH_W   [NUM_CH] = '{5, 6, 5};

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF   = 2'd0,
    MODE_MASK  = 2'd1,
    MODE_BLEND = 2'd2,
    MODE_BOTH  = 2'd3
  } modeT;

  typedef struct packed {
    logic load;
    logic blendEn;
    logic fgIsReg;
  } strobeT;

  function automatic logic [CH_MAXW-1:0] mixChannel(
      input logic [CH_MAXW-1:0] fg,
      input logic [CH_MAXW-1:0] bg,
      input logic [ALPHA_W-1:0] alpha);
    logic [ACC_W-1:0] acc;
    acc = ACC_W'(alpha) * ACC_W'(fg)
        + (ACC_W'(1 << ALPHA_W) - ACC_W'(alpha)) * ACC_W'(bg);
    return acc[ALPHA_W +: CH_MAXW];
  endfunction
endpackage

// File: rtl/pbu_ctrl.sv
module pbu_ctrl
  import pbu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              cfgSrcSel,
  input  logic              inValid,
  input  logic              outReady,
  input  logic              maskHit,
  output strobeT            strb,
  output logic              outValid
);
  logic maskEn;
  logic dropPix;
  logic accept;

  assign maskEn  = cfgMode[0];
  assign dropPix = maskEn && maskHit;
  assign accept  = inValid && outReady;

  always_comb begin
    strb.load    = accept && !dropPix;
    strb.blendEn = cfgMode[1];
    strb.fgIsReg = cfgSrcSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else if (outReady) begin
      outValid <= accept && !dropPix;
    end
  end
endmodule

// File: rtl/pbu_datapath.sv
module pbu_datapath
  import pbu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [PIX_W-1:0]   inData,
  input  logic [PIX_W-1:0]   cfgMask,
  input  logic [ALPHA_W-1:0] cfgAlpha,
  input  logic [PIX_W-1:0]   cfgPixel0,
  input  logic [PIX_W-1:0]   cfgPixel1,
  output logic               maskHit,
  output logic [PIX_W-1:0]   outData
);
  logic [PIX_W-1:0] fgPix;
  logic [PIX_W-1:0] bgPix;
  logic [PIX_W-1:0] mixed;
  logic [PIX_W-1:0] nextPix;

  assign maskHit = (inData == cfgMask);
  assign fgPix   = strb.fgIsReg ? cfgPixel1 : inData;
  assign bgPix   = strb.fgIsReg ? inData : cfgPixel0;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    localparam int LSB = CH_LSB[g];
    localparam int W   = CH_W[g];
    logic [CH_MAXW-1:0] chRes;
    assign chRes = mixChannel(CH_MAXW'(fgPix[LSB +: W]),
                              CH_MAXW'(bgPix[LSB +: W]), cfgAlpha);
    assign mixed[LSB +: W] = chRes[W-1:0];
  end

  assign nextPix = strb.blendEn ? mixed : inData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
    end else if (strb.load) begin
      outData <= nextPix;
    end
  end
endmodule

// File: rtl/pix_blend_unit.sv
module pix_blend_unit
  import pbu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [MODE_W-1:0]  cfgMode,
  input  logic [PIX_W-1:0]   cfgMask,
  input  logic [ALPHA_W-1:0] cfgAlpha,
  input  logic [PIX_W-1:0]   cfgPixel0,
  input  logic [PIX_W-1:0]   cfgPixel1,
  input  logic               cfgSrcSel,
  input  logic               inValid,
  input  logic [PIX_W-1:0]   inData,
  output logic               inReady,
  output logic               outValid,
  output logic [PIX_W-1:0]   outData,
  input  logic               outReady
);
  strobeT strb;
  logic   maskHit;

  assign inReady = outReady;

  pbu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgSrcSel(cfgSrcSel),
    .inValid(inValid), .outReady(outReady), .maskHit(maskHit),
    .strb(strb), .outValid(outValid)
  );

  pbu_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .cfgMask(cfgMask), .cfgAlpha(cfgAlpha), .cfgPixel0(cfgPixel0),
    .cfgPixel1(cfgPixel1), .maskHit(maskHit), .outData(outData)
  );
endmodule

// File: rtl/pbu_checker.sv
module pbu_checker
  import pbu_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [MODE_W-1:0]  cfgMode,
  input logic [PIX_W-1:0]   cfgMask,
  input logic [ALPHA_W-1:0] cfgAlpha,
  input logic [PIX_W-1:0]   cfgPixel0,
  input logic [PIX_W-1:0]   cfgPixel1,
  input logic               cfgSrcSel,
  input logic               inValid,
  input logic [PIX_W-1:0]   inData,
  input logic               inReady,
  input logic               outValid,
  input logic [PIX_W-1:0]   outData,
  input logic               outReady
);
  logic takePix;
  assign takePix = inValid && inReady;

  assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_pass_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (takePix && cfgMode == 2'd0) |=> (outValid && outData == $past(inData)));

  assert_drop_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    (takePix && cfgMode[0] && inData == cfgMask) |=> (!outValid && $stable(outData)));

  assert_emit_nomatch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (takePix && !(cfgMode[0] && inData == cfgMask)) |=> outValid);

  assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && !inValid) |=> !outValid);

  assert_mask_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (takePix && cfgMode == 2'd1 && inData != cfgMask) |=> (outData == $past(inData)));

  assert_alpha_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (takePix && cfgMode == 2'd2 && cfgAlpha == '0)
      |=> (outData == $past(cfgSrcSel ? inData : cfgPixel0)));
endmodule

bind pix_blend_unit pbu_checker uChk (.*);

// File: tb/pix_blend_unit_test.sv
module pix_blend_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic [15:0] cfgMask = 16'h0;
  logic [7:0]  cfgAlpha = 8'h0;
  logic [15:0] cfgPixel0 = 16'h0;
  logic [15:0] cfgPixel1 = 16'h0;
  logic        cfgSrcSel = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inData = 16'h0;
  logic        inReady;
  logic        outValid;
  logic [15:0] outData;
  logic        outReady = 1'b1;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pix_blend_unit uut (.*);

  function automatic int mixC(int fg, int bg, int al);
    return (al * fg + (256 - al) * bg) >> 8;
  endfunction

  function automatic logic [15:0] blendRef(logic [15:0] fg, logic [15:0] bg, int al);
    logic [15:0] r;
    r[15:11] = 5'(mixC(int'(fg[15:11]), int'(bg[15:11]), al));
    r[10:5]  = 6'(mixC(int'(fg[10:5]),  int'(bg[10:5]),  al));
    r[4:0]   = 5'(mixC(int'(fg[4:0]),   int'(bg[4:0]),   al));
    return r;
  endfunction

  function automatic logic [15:0] expectRef(logic [15:0] pix);
    if (!cfgMode[1]) return pix;
    if (cfgSrcSel) return blendRef(cfgPixel1, pix, int'(cfgAlpha));
    return blendRef(pix, cfgPixel0, int'(cfgAlpha));
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Send one pixel with outReady high; check the cycle after acceptance.
  task automatic sendPix(string req, logic [15:0] pix);
    logic [15:0] prev;
    logic        drop;
    logic [15:0] exp;
    @(negedge clk);
    prev = outData;
    drop = cfgMode[0] && (pix == cfgMask);
    exp  = expectRef(pix);
    outReady = 1'b1;
    inValid = 1'b1;
    inData = pix;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    check({req, " valid"}, 16'(outValid), drop ? 16'd0 : 16'd1);
    check({req, " data"}, outData, drop ? prev : exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (2) @(posedge clk);
    #1 check("R1 in reset", 16'(outValid), 16'd0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1 check("R1 after reset", 16'(outValid), 16'd0);

    // R5/R2: pass-through in mode 0
    cfgMode = 2'd0; cfgMask = 16'hABCD;
    sendPix("R5 off passthru", 16'hABCD);
    sendPix("R2 latency", 16'h1234);
    @(posedge clk); #1 check("R2 idle clears valid", 16'(outValid), 16'd0);

    // R6/R7: mask only
    cfgMode = 2'd1; cfgMask = 16'h07E0;
    sendPix("R7 mask nonmatch", 16'hF800);
    sendPix("R6 mask drop", 16'h07E0);
    // R7: blend only ignores mask
    cfgMode = 2'd2; cfgAlpha = 8'd255; cfgSrcSel = 1'b0; cfgPixel0 = 16'h0000;
    sendPix("R7 blend no drop", 16'h07E0);

    // R8/R9: directed blend values
    cfgAlpha = 8'd128; cfgPixel0 = 16'hFFFF;
    sendPix("R8 half blend src mem", 16'h0000);
    check("R8 half value", outData, {5'd15, 6'd31, 5'd15});
    cfgSrcSel = 1'b1; cfgPixel1 = 16'hF81F;
    sendPix("R9 src reg1", 16'h07E0);
    // R11: alpha zero gives background
    cfgAlpha = 8'd0;
    sendPix("R11 alpha0 reg1 src", 16'h5A5A);
    check("R11 bg is stream", outData, 16'h5A5A);
    cfgSrcSel = 1'b0; cfgPixel0 = 16'h1357;
    sendPix("R11 alpha0 mem src", 16'hFFFF);
    check("R11 bg is pixel0", outData, 16'h1357);

    // R10: mode 3 masks raw pixel, not blended value
    cfgMode = 2'd3; cfgSrcSel = 1'b1; cfgPixel1 = 16'hFFFF; cfgAlpha = 8'd128;
    cfgMask = blendRef(16'hFFFF, 16'h0000, 128);
    sendPix("R10 blended equals mask kept", 16'h0000);
    cfgMask = 16'h4321;
    sendPix("R10 raw match dropped", 16'h4321);

    // R3: stall holds output, inReady follows outReady
    cfgMode = 2'd0;
    sendPix("R3 pre-stall", 16'hAAAA);
    @(negedge clk);
    outReady = 1'b0; inValid = 1'b1; inData = 16'h5555;
    #1 check("R3 inReady low", 16'(inReady), 16'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check("R3 hold valid", 16'(outValid), 16'd1);
      check("R3 hold data", outData, 16'hAAAA);
    end
    @(negedge clk) outReady = 1'b1;
    #1 check("R3 inReady high", 16'(inReady), 16'd1);
    @(posedge clk); #1;
    inValid = 1'b0;
    check("R3 release data", outData, 16'h5555);

    // Random mix over all modes (R4 encoding, R8, R9, R6)
    for (int i = 0; i < 400; i++) begin
      logic [15:0] pix;
      cfgMode   = 2'($urandom_range(0, 3));
      cfgSrcSel = 1'($urandom_range(0, 1));
      cfgAlpha  = 8'($urandom);
      cfgPixel0 = 16'($urandom);
      cfgPixel1 = 16'($urandom);
      pix       = 16'($urandom);
      cfgMask   = ($urandom_range(0, 3) == 0) ? pix : 16'($urandom);
      sendPix("R4 random", pix);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule